// File: doc/BRIEF.md
# Multichannel Pulse Generator with Buffered Edge Registers

This block drives a bank of pulse-width-modulated outputs from one free-running period counter. Each channel holds two edge positions: the count at which its output goes high and the count at which it goes low again. Software programs the period, the edge positions and a single control bit through a zero-wait-state, APB-style register bus.

A build-time bit mask decides, channel by channel, whether that channel also gets a pair of buffer registers in front of its live edge registers. For channels built that way, the control bit picks the update policy. With the bit set, bus writes land in the buffers and both edges move into the live registers together on the cycle the counter wraps, so a pulse is never formed from one old and one new edge. With the bit clear, writes take effect immediately. Channels built without buffers always update immediately. Reads always return what software last wrote.

Top module: `pwm_bank`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, every output is low and the counter is 0; after reset the period register reads `PERIOD_RST`, the control register reads 0 and every edge register reads 0.
- R2: The counter steps by one per clock from 0 and, on a cycle where it is greater than or equal to the period register, returns to 0, so one period lasts period+1 cycles.
- R3: Output `pwm_o[c]` is high in the cycle after the counter held a value v with rise(c) <= v < fall(c), using the live edge values, and low otherwise.
- R4: When the live rise value equals or exceeds the live fall value, the channel stays low for the whole period.
- R5: For a channel whose bit in `SHADOW_EN` is 0, a write to either edge register becomes live on the clock edge that completes the write, whatever the control bit holds.
- R6: For a channel whose bit in `SHADOW_EN` is 1, with control bit 0 clear, a write becomes live on the clock edge that completes it.
- R7: For a channel whose bit in `SHADOW_EN` is 1, with control bit 0 set, the live edges hold their values except on the counter's wrap cycle, where both take the buffered values held before that edge.
- R8: A read of an edge register returns the value last written to it, even while that value is still waiting in a buffer.
- R9: Clearing control bit 0 while buffered values are pending makes them live on the next clock edge.
- R10: Address map (6-bit word addresses): 0x00 period, 0x01 control with bit 0 the update-sync bit and the other bits reading 0, 0x20+2c rise edge of channel c, 0x21+2c fall edge of channel c. Writes to any other address, or to a channel number at or above `NCH`, change nothing and such addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 6 | Word address |
| pwdata | input | CW | Write data |
| prdata | output | CW | Read data, registered, valid in the access phase |
| pwm_o | output | NCH | Pulse outputs, registered |

## Verification
A write is complete on the rising edge that ends its access phase; under the immediate policy the edge value is live after that edge and the output shows it one edge later, since the output is itself a register fed from the counter. Read data is registered on the edge that ends the setup phase and is sampled during the access phase. Buffered values go live on the wrap edge, and outputs reflect them from the following edge. The bench steps its own model on every rising edge from the same bus inputs and compares every output at each falling edge, so each of these latencies is checked to the exact cycle.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  localparam int AW = 6;

  localparam logic [AW-1:0] A_PERIOD = 6'h00;
  localparam logic [AW-1:0] A_CTRL   = 6'h01;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_PERIOD,
    SEL_CTRL,
    SEL_CHAN
  } regsel_e;

  typedef struct packed {
    regsel_e    sel;
    logic [3:0] ch;
    logic       is_fall;
  } dec_t;

  function automatic dec_t decode_addr(input logic [AW-1:0] a, input int nch);
    dec_t d;
    d.sel     = SEL_NONE;
    d.ch      = a[4:1];
    d.is_fall = a[0];
    if (a == A_PERIOD)                     d.sel = SEL_PERIOD;
    else if (a == A_CTRL)                  d.sel = SEL_CTRL;
    else if (a[5] && (int'(a[4:1]) < nch)) d.sel = SEL_CHAN;
    return d;
  endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] cnt,
  output logic          wrap
);

  assign wrap = (cnt >= period);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CW         = 8,
  parameter bit HAS_SHADOW = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_en,
  input  logic          wrap,
  input  logic [CW-1:0] cnt,
  input  logic          wr_rise,
  input  logic          wr_fall,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rd_rise,
  output logic [CW-1:0] rd_fall,
  output logic          pwm_o
);

  logic [CW-1:0] act_rise;
  logic [CW-1:0] act_fall;

  generate
    if (HAS_SHADOW) begin : g_shadow
      logic [CW-1:0] buf_rise;
      logic [CW-1:0] buf_fall;
      logic [CW-1:0] nxt_rise;
      logic [CW-1:0] nxt_fall;

      assign nxt_rise = wr_rise ? wdata : buf_rise;
      assign nxt_fall = wr_fall ? wdata : buf_fall;

      always_ff @(posedge clk) begin
        if (rst) begin
          buf_rise <= '0;
          buf_fall <= '0;
          act_rise <= '0;
          act_fall <= '0;
        end else begin
          buf_rise <= nxt_rise;
          buf_fall <= nxt_fall;
          if (!sync_en) begin
            act_rise <= nxt_rise;
            act_fall <= nxt_fall;
          end else if (wrap) begin
            act_rise <= buf_rise;
            act_fall <= buf_fall;
          end
        end
      end

      assign rd_rise = buf_rise;
      assign rd_fall = buf_fall;
    end else begin : g_direct
      logic unused_policy;
      assign unused_policy = sync_en ^ wrap;

      always_ff @(posedge clk) begin
        if (rst) begin
          act_rise <= '0;
          act_fall <= '0;
        end else begin
          if (wr_rise) act_rise <= wdata;
          if (wr_fall) act_fall <= wdata;
        end
      end

      assign rd_rise = act_rise;
      assign rd_fall = act_fall;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) pwm_o <= 1'b0;
    else     pwm_o <= (cnt >= act_rise) && (cnt < act_fall);
  end

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_pkg::*;
#(
  parameter int              NCH        = 4,
  parameter int              CW         = 8,
  parameter logic [15:0]     SHADOW_EN  = 16'h0005,
  parameter logic [CW-1:0]   PERIOD_RST = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [5:0]    paddr,
  input  logic [CW-1:0] pwdata,
  output logic [CW-1:0] prdata,
  output logic [NCH-1:0] pwm_o
);

  logic          wr_en;
  dec_t          adec;
  logic [CW-1:0] period_q;
  logic          sync_q;
  logic [CW-1:0] cnt;
  logic          wrap;
  logic [CW-1:0] rd_rise [NCH];
  logic [CW-1:0] rd_fall [NCH];
  logic [CW-1:0] rmux;

  assign wr_en = psel && penable && pwrite;
  assign adec  = decode_addr(paddr, NCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= PERIOD_RST;
      sync_q   <= 1'b0;
    end else if (wr_en) begin
      if (adec.sel == SEL_PERIOD) period_q <= pwdata;
      if (adec.sel == SEL_CTRL)   sync_q   <= pwdata[0];
    end
  end

  pwm_timebase #(.CW(CW)) u_timebase (
    .clk    (clk),
    .rst    (rst),
    .period (period_q),
    .cnt    (cnt),
    .wrap   (wrap)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic hit;
      assign hit = wr_en && (adec.sel == SEL_CHAN) && (adec.ch == 4'(c));

      pwm_chan #(.CW(CW), .HAS_SHADOW(SHADOW_EN[c])) u_chan (
        .clk     (clk),
        .rst     (rst),
        .sync_en (sync_q),
        .wrap    (wrap),
        .cnt     (cnt),
        .wr_rise (hit && !adec.is_fall),
        .wr_fall (hit &&  adec.is_fall),
        .wdata   (pwdata),
        .rd_rise (rd_rise[c]),
        .rd_fall (rd_fall[c]),
        .pwm_o   (pwm_o[c])
      );
    end
  endgenerate

  always_comb begin
    rmux = '0;
    case (adec.sel)
      SEL_PERIOD: rmux = period_q;
      SEL_CTRL:   rmux = {{(CW-1){1'b0}}, sync_q};
      SEL_CHAN: begin
        for (int i = 0; i < NCH; i++) begin
          if (adec.ch == 4'(i)) rmux = adec.is_fall ? rd_fall[i] : rd_rise[i];
        end
      end
      default:    rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) prdata <= '0;
    else     prdata <= rmux;
  end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NCH = 4,
  parameter int CW  = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [CW-1:0]  cnt,
  input logic [CW-1:0]  period_q,
  input logic [NCH-1:0] pwm_o
);

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cnt == '0) && (pwm_o == '0));

  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (cnt >= period_q) |=> (cnt == '0));

  a_r2_step_by_one: assert property (@(posedge clk) disable iff (rst)
    (cnt < period_q) |=> (cnt == $past(cnt) + 1'b1));

endmodule

module pwm_chan_chk #(
  parameter int CW         = 8,
  parameter bit HAS_SHADOW = 1'b0
) (
  input logic          clk,
  input logic          rst,
  input logic          sync_en,
  input logic          wrap,
  input logic          wr_rise,
  input logic          wr_fall,
  input logic [CW-1:0] wdata,
  input logic [CW-1:0] rd_rise,
  input logic [CW-1:0] rd_fall,
  input logic [CW-1:0] act_rise,
  input logic [CW-1:0] act_fall
);

  generate
    if (HAS_SHADOW) begin : g_sh
      a_r7_hold_between_wraps: assert property (@(posedge clk) disable iff (rst)
        (sync_en && !wrap) |=> $stable(act_rise) && $stable(act_fall));

      a_r7_load_on_wrap: assert property (@(posedge clk) disable iff (rst)
        (sync_en && wrap) |=> (act_rise == $past(rd_rise)) && (act_fall == $past(rd_fall)));

      a_r6_async_rise: assert property (@(posedge clk) disable iff (rst)
        (!sync_en && wr_rise) |=> (act_rise == $past(wdata)));

      a_r6_async_fall: assert property (@(posedge clk) disable iff (rst)
        (!sync_en && wr_fall) |=> (act_fall == $past(wdata)));
    end else begin : g_dir
      a_r5_direct_rise: assert property (@(posedge clk) disable iff (rst)
        wr_rise |=> (act_rise == $past(wdata)));

      a_r5_direct_fall: assert property (@(posedge clk) disable iff (rst)
        wr_fall |=> (act_fall == $past(wdata)));
    end
  endgenerate

  a_r8_readback_rise: assert property (@(posedge clk) disable iff (rst)
    wr_rise |=> (rd_rise == $past(wdata)));

  a_r8_readback_fall: assert property (@(posedge clk) disable iff (rst)
    wr_fall |=> (rd_fall == $past(wdata)));

endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .CW(CW)) u_bank_chk (
  .clk      (clk),
  .rst      (rst),
  .cnt      (cnt),
  .period_q (period_q),
  .pwm_o    (pwm_o)
);

bind pwm_chan pwm_chan_chk #(.CW(CW), .HAS_SHADOW(HAS_SHADOW)) u_chan_chk (
  .clk      (clk),
  .rst      (rst),
  .sync_en  (sync_en),
  .wrap     (wrap),
  .wr_rise  (wr_rise),
  .wr_fall  (wr_fall),
  .wdata    (wdata),
  .rd_rise  (rd_rise),
  .rd_fall  (rd_fall),
  .act_rise (act_rise),
  .act_fall (act_fall)
);

// File: tb/test_pwm_bank.sv
module test_pwm_bank;

  localparam int          NCH = 4;
  localparam int          CW  = 8;
  localparam logic [15:0] SH  = 16'h0005;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          psel = 1'b0;
  logic          penable = 1'b0;
  logic          pwrite = 1'b0;
  logic [5:0]    paddr = '0;
  logic [CW-1:0] pwdata = '0;
  logic [CW-1:0] prdata;
  logic [NCH-1:0] pwm_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit chk_on = 1'b0;
  string cur_tag = "R3";

  pwm_bank #(.NCH(NCH), .CW(CW), .SHADOW_EN(SH), .PERIOD_RST(8'hFF)) i_pwm_bank (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pwm_o(pwm_o)
  );

  always #5 clk = ~clk;

  // reference model, stepped on every rising edge
  logic [CW-1:0]  m_cnt, m_period;
  logic           m_sync;
  logic [CW-1:0]  m_rise [NCH];
  logic [CW-1:0]  m_fall [NCH];
  logic [CW-1:0]  m_ar [NCH];
  logic [CW-1:0]  m_af [NCH];
  logic [NCH-1:0] exp_pwm;
  logic           m_wrap, m_wr, m_sh;
  logic [CW-1:0]  ob_r, ob_f, nb_r, nb_f;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = '0; m_period = 8'hFF; m_sync = 1'b0; exp_pwm = '0;
      for (int c = 0; c < NCH; c++) begin
        m_rise[c] = '0; m_fall[c] = '0; m_ar[c] = '0; m_af[c] = '0;
      end
    end else begin
      for (int c = 0; c < NCH; c++)
        exp_pwm[c] = (m_cnt >= m_ar[c]) && (m_cnt < m_af[c]);
      m_wrap = (m_cnt >= m_period);
      m_wr   = psel && penable && pwrite;
      for (int c = 0; c < NCH; c++) begin
        m_sh = SH[c] && m_sync;
        ob_r = m_rise[c]; ob_f = m_fall[c];
        nb_r = (m_wr && paddr == 6'(32 + 2*c)) ? pwdata : ob_r;
        nb_f = (m_wr && paddr == 6'(33 + 2*c)) ? pwdata : ob_f;
        m_rise[c] = nb_r; m_fall[c] = nb_f;
        if (m_sh) begin
          if (m_wrap) begin m_ar[c] = ob_r; m_af[c] = ob_f; end
        end else begin
          m_ar[c] = nb_r; m_af[c] = nb_f;
        end
      end
      if (m_wr && paddr == 6'h00) m_period = pwdata;
      if (m_wr && paddr == 6'h01) m_sync = pwdata[0];
      m_cnt = m_wrap ? '0 : m_cnt + 1'b1;
    end
  end

  function automatic logic [CW-1:0] exp_read(input logic [5:0] a);
    if (a == 6'h00) return m_period;
    if (a == 6'h01) return {7'b0, m_sync};
    if (a[5] && int'(a[4:1]) < NCH) return a[0] ? m_fall[a[4:1]] : m_rise[a[4:1]];
    return '0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on)
      for (int c = 0; c < NCH; c++) check(cur_tag, pwm_o[c], exp_pwm[c]);
  end

  task automatic bus_write(input logic [5:0] a, input logic [CW-1:0] d);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_read(input logic [5:0] a, input string tag);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1;
    check(tag, prdata, exp_read(a));
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_high(input int cycles, input int ch, input int exp, input string tag);
    int ones = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pwm_o[ch]) ones++;
    end
    check(tag, ones, exp);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int r;
    r = $urandom(32'd20240611);
    idle(3);
    check("R1", pwm_o, 0);
    @(negedge clk); rst = 0;
    check("R1", pwm_o, 0);
    chk_on = 1;
    bus_read(6'h00, "R1");
    bus_read(6'h01, "R1");
    bus_read(6'h20, "R1");
    bus_read(6'h27, "R1");

    // basic shapes, immediate policy
    cur_tag = "R3";
    bus_write(6'h00, 8'd9);
    bus_write(6'h20, 8'd2); bus_write(6'h21, 8'd7);
    bus_write(6'h22, 8'd0); bus_write(6'h23, 8'd5);
    cur_tag = "R4";
    bus_write(6'h24, 8'd3); bus_write(6'h25, 8'd3);
    bus_write(6'h26, 8'd6); bus_write(6'h27, 8'd2);
    idle(12);
    count_high(20, 0, 10, "R2");
    count_high(20, 1, 10, "R3");
    count_high(20, 2, 0, "R4");
    count_high(20, 3, 0, "R4");

    // synchronized policy on shadowed channels
    cur_tag = "R7";
    bus_write(6'h01, 8'h01);
    bus_write(6'h20, 8'd1); bus_write(6'h21, 8'd9);
    bus_read(6'h20, "R8");
    bus_read(6'h21, "R8");
    cur_tag = "R5";
    bus_write(6'h22, 8'd4);
    idle(25);

    // pending values released by clearing the sync bit
    cur_tag = "R9";
    bus_write(6'h24, 8'd1); bus_write(6'h25, 8'd8);
    bus_read(6'h25, "R8");
    bus_write(6'h01, 8'h00);
    idle(12);

    // immediate policy on a shadowed channel
    cur_tag = "R6";
    bus_write(6'h24, 8'd5); bus_write(6'h25, 8'd7);
    idle(12);

    // address map edges
    cur_tag = "R10";
    bus_write(6'h10, 8'hAA);
    bus_write(6'h2A, 8'h55);
    bus_write(6'h3F, 8'h33);
    bus_read(6'h10, "R10");
    bus_read(6'h2A, "R10");
    bus_read(6'h3F, "R10");
    bus_read(6'h21, "R10");
    bus_write(6'h01, 8'hFE);
    bus_read(6'h01, "R10");
    bus_write(6'h01, 8'hFF);
    bus_read(6'h01, "R10");
    idle(12);

    // random mix
    cur_tag = "R7";
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom % 10;
      if (op < 5)       bus_write(6'(32 + ($urandom % (2*NCH))), 8'($urandom % 16));
      else if (op == 5) bus_write(6'h00, 8'(3 + $urandom % 13));
      else if (op == 6) bus_write(6'h01, 8'($urandom % 2));
      else              bus_read(6'($urandom % 64), "R8");
      idle($urandom % 6);
    end

    idle(20);
    chk_on = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule